// File: doc/BRIEF.md
# GPIO Pin Interrupt Unit

This block turns a set of already-synchronized GPIO input levels into interrupt requests. It does not drive or read the pads. Each pin has its own trigger setting. It can be level-sensitive, firing while the pin sits at a chosen level. It can instead be edge-sensitive, firing on a rising edge, on a falling edge, or on both edges. Edge events are latched in a sticky status bit until software clears them. Level events are never latched: they follow the pin from cycle to cycle.

Software reaches the unit through a simple single-cycle register bus. A write takes effect at the clock edge. Read data is combinational while a read is presented. Software picks the trigger mode, the polarity and the enable mask per pin. It reads raw and masked status and clears latched edges by writing ones. One registered output goes high whenever any enabled pin has pending status.

Top module: `gpirq_unit`

## Requirements
- R1: After reset all configuration fields, the raw status, the masked status and `irq_out` read as zero.
- R2: The trigger-kind field (offset 0x404, 1 = level, 0 = edge), the dual-edge field (0x408), the polarity field (0x40C, 1 = high/rising, 0 = low/falling) and the enable field (0x410) each read back the last value written at their offset. Bit n always refers to pin n.
- R3: An edge-mode pin with dual-edge 0 and polarity 1 sets its raw status bit (read at 0x414) at the clock edge where its input is first seen high after being low. A falling transition does not set it.
- R4: An edge-mode pin with dual-edge 0 and polarity 0 sets its raw status bit on a high-to-low transition only.
- R5: An edge-mode pin with dual-edge 1 sets its raw status bit on either transition, whatever its polarity bit holds.
- R6: A latched edge bit stays set after the pin changes back. Writing 1 to that bit at offset 0x41C clears it at the next clock edge. Writing 0 there leaves it set.
- R7: When a new qualifying edge and a clear for the same pin land on the same clock edge, the bit ends up set.
- R8: A level-mode pin's raw status bit equals (pin == polarity) in the same cycle, with no latching. A clear write does not change it.
- R9: Masked status at offset 0x418 equals raw status AND the enable field.
- R10: `irq_out` is the OR of all masked status bits, registered: it shows the value present in the previous cycle.
- R11: Writes to offsets 0x414 and 0x418 change nothing. Reads of 0x41C or of any unmapped offset return zero.
- R12: While a pin is in level mode, its edge latch is held clear. Switching the pin back to edge mode therefore shows no stale event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Synchronized pin levels |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data, valid while a read is presented |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
A corrupted edge latch shows up in the raw status read right after the clock edge that should have changed it. One cycle later it also shows on `irq_out`, if the pin is enabled. A wrong stored previous sample appears as a missed or spurious event on the next input transition of that pin. Wrong configuration storage shows at once in readback, and it changes which transitions set status. To reach every one of these paths, each pin is swept through all five trigger settings while its neighbours run other settings. The status is compared against an arithmetic model after every clock edge.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

    localparam int ADDR_W = 12;
    typedef logic [ADDR_W-1:0] addr_t;

    // register offsets seen by software
    localparam addr_t OFS_KIND   = 12'h404;
    localparam addr_t OFS_DUAL   = 12'h408;
    localparam addr_t OFS_POL    = 12'h40C;
    localparam addr_t OFS_ENABLE = 12'h410;
    localparam addr_t OFS_RAW    = 12'h414;
    localparam addr_t OFS_MASKED = 12'h418;
    localparam addr_t OFS_CLEAR  = 12'h41C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KIND,
        SEL_DUAL,
        SEL_POL,
        SEL_ENABLE,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLEAR
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input addr_t a);
        reg_sel_e s;
        case (a)
            OFS_KIND:   s = SEL_KIND;
            OFS_DUAL:   s = SEL_DUAL;
            OFS_POL:    s = SEL_POL;
            OFS_ENABLE: s = SEL_ENABLE;
            OFS_RAW:    s = SEL_RAW;
            OFS_MASKED: s = SEL_MASKED;
            OFS_CLEAR:  s = SEL_CLEAR;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpirq_regs.sv
module gpirq_regs
    import gpirq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  addr_t            bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    input  logic [NPINS-1:0] raw_sts,
    input  logic [NPINS-1:0] masked_sts,
    output logic [NPINS-1:0] lvl_sel,
    output logic [NPINS-1:0] dual_edge,
    output logic [NPINS-1:0] pol_hi,
    output logic [NPINS-1:0] irq_en,
    output logic [NPINS-1:0] clr_pulse,
    output logic [NPINS-1:0] bus_rdata
);

    typedef struct packed {
        logic [NPINS-1:0] kind;
        logic [NPINS-1:0] dual;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] enable;
    } cfg_t;

    cfg_t     cfg_d, cfg_q;
    reg_sel_e sel;
    logic     wr_go;
    logic     rd_go;

    always_comb begin
        cfg_d     = cfg_q;
        sel       = decode_addr(bus_addr);
        wr_go     = bus_sel && bus_wr;
        rd_go     = bus_sel && !bus_wr;
        clr_pulse = '0;
        bus_rdata = '0;

        if (wr_go) begin
            case (sel)
                SEL_KIND:   cfg_d.kind   = bus_wdata;
                SEL_DUAL:   cfg_d.dual   = bus_wdata;
                SEL_POL:    cfg_d.pol    = bus_wdata;
                SEL_ENABLE: cfg_d.enable = bus_wdata;
                SEL_CLEAR:  clr_pulse    = bus_wdata;
                default:    ;  // status offsets are read-only
            endcase
        end

        if (rd_go) begin
            case (sel)
                SEL_KIND:   bus_rdata = cfg_q.kind;
                SEL_DUAL:   bus_rdata = cfg_q.dual;
                SEL_POL:    bus_rdata = cfg_q.pol;
                SEL_ENABLE: bus_rdata = cfg_q.enable;
                SEL_RAW:    bus_rdata = raw_sts;
                SEL_MASKED: bus_rdata = masked_sts;
                default:    bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign lvl_sel   = cfg_q.kind;
    assign dual_edge = cfg_q.dual;
    assign pol_hi    = cfg_q.pol;
    assign irq_en    = cfg_q.enable;

endmodule

// File: rtl/gpirq_detect.sv
module gpirq_detect #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] lvl_sel,
    input  logic [NPINS-1:0] dual_edge,
    input  logic [NPINS-1:0] pol_hi,
    output logic [NPINS-1:0] edge_hit
);

    typedef struct packed {
        logic [NPINS-1:0] prev;
    } det_t;

    det_t det_d, det_q;
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] fall;

    always_comb begin
        det_d      = det_q;
        det_d.prev = pin_in;
        rise       = pin_in & ~det_q.prev;
        fall       = ~pin_in & det_q.prev;
    end

    // per-pin event qualification
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic wanted;
        always_comb begin
            if (dual_edge[g]) wanted = rise[g] | fall[g];
            else if (pol_hi[g]) wanted = rise[g];
            else                wanted = fall[g];
        end
        assign edge_hit[g] = wanted & ~lvl_sel[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

endmodule

// File: rtl/gpirq_status.sv
module gpirq_status #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] lvl_sel,
    input  logic [NPINS-1:0] pol_hi,
    input  logic [NPINS-1:0] irq_en,
    input  logic [NPINS-1:0] edge_hit,
    input  logic [NPINS-1:0] clr_pulse,
    output logic [NPINS-1:0] raw_sts,
    output logic [NPINS-1:0] masked_sts,
    output logic [NPINS-1:0] edge_latched,
    output logic             irq_out
);

    typedef struct packed {
        logic [NPINS-1:0] latch;
        logic             irq;
    } sts_t;

    sts_t sts_d, sts_q;

    // level pins follow the input, edge pins show the latch
    for (genvar g = 0; g < NPINS; g++) begin : g_raw
        assign raw_sts[g] = lvl_sel[g] ? (pin_in[g] == pol_hi[g]) : sts_q.latch[g];
    end

    always_comb begin
        sts_d       = sts_q;
        masked_sts  = raw_sts & irq_en;
        // a fresh event outranks a clear; level pins keep the latch empty
        sts_d.latch = ((sts_q.latch & ~clr_pulse) | edge_hit) & ~lvl_sel;
        sts_d.irq   = |masked_sts;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign edge_latched = sts_q.latch;
    assign irq_out      = sts_q.irq;

endmodule

// File: rtl/gpirq_unit.sv
module gpirq_unit
    import gpirq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [11:0]      bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    output logic             irq_out
);

    logic [NPINS-1:0] lvl_w;
    logic [NPINS-1:0] dual_w;
    logic [NPINS-1:0] pol_w;
    logic [NPINS-1:0] en_w;
    logic [NPINS-1:0] clr_w;
    logic [NPINS-1:0] hit_w;
    logic [NPINS-1:0] raw_w;
    logic [NPINS-1:0] masked_w;
    logic [NPINS-1:0] edge_w;

    gpirq_regs #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .raw_sts    (raw_w),
        .masked_sts (masked_w),
        .lvl_sel    (lvl_w),
        .dual_edge  (dual_w),
        .pol_hi     (pol_w),
        .irq_en     (en_w),
        .clr_pulse  (clr_w),
        .bus_rdata  (bus_rdata)
    );

    gpirq_detect #(.NPINS(NPINS)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .lvl_sel   (lvl_w),
        .dual_edge (dual_w),
        .pol_hi    (pol_w),
        .edge_hit  (hit_w)
    );

    gpirq_status #(.NPINS(NPINS)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_in       (pin_in),
        .lvl_sel      (lvl_w),
        .pol_hi       (pol_w),
        .irq_en       (en_w),
        .edge_hit     (hit_w),
        .clr_pulse    (clr_w),
        .raw_sts      (raw_w),
        .masked_sts   (masked_w),
        .edge_latched (edge_w),
        .irq_out      (irq_out)
    );

endmodule

// File: rtl/gpirq_unit_chk.sv
module gpirq_unit_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pin_in,
    input logic             irq_out,
    input logic [NPINS-1:0] lvl_sel,
    input logic [NPINS-1:0] pol_hi,
    input logic [NPINS-1:0] irq_en,
    input logic [NPINS-1:0] raw_sts,
    input logic [NPINS-1:0] masked_sts,
    input logic [NPINS-1:0] edge_latched,
    input logic [NPINS-1:0] clr_pulse,
    input logic [NPINS-1:0] edge_hit
);

    AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_sts & ~irq_en) == '0);  // R9

    AST_IRQ_LAGS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|$past(masked_sts)));  // R10

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_latched & ~clr_pulse & ~lvl_sel) & ~edge_latched) == '0);  // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_pulse & ~edge_hit) & edge_latched) == '0);  // R6

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_hit) & ~edge_latched) == '0);  // R7

    AST_LEVEL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_sts ^ ~(pin_in ^ pol_hi)) & lvl_sel) == '0);  // R8

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_latched & $past(lvl_sel)) == '0);  // R12

    AST_NO_EVENT_IN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit & lvl_sel) == '0);  // R12

endmodule

bind gpirq_unit gpirq_unit_chk #(.NPINS(NPINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_in       (pin_in),
    .irq_out      (irq_out),
    .lvl_sel      (lvl_w),
    .pol_hi       (pol_w),
    .irq_en       (en_w),
    .raw_sts      (raw_w),
    .masked_sts   (masked_w),
    .edge_latched (edge_w),
    .clr_pulse    (clr_w),
    .edge_hit     (hit_w)
);

// File: tb/gpirq_unit_bench.sv
`timescale 1ns/1ps
module gpirq_unit_bench;

    localparam int NP = 8;
    localparam logic [11:0] A_KIND = 12'h404, A_DUAL = 12'h408, A_POL = 12'h40C,
                            A_EN = 12'h410, A_RAW = 12'h414, A_MSK = 12'h418,
                            A_CLR = 12'h41C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic          irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model of the requirements
    logic [NP-1:0] m_lvl = '0, m_dual = '0, m_pol = '0, m_en = '0;
    logic [NP-1:0] m_latch = '0, m_prev = '0;
    logic          m_irq = 1'b0;

    always #4 clk = ~clk;

    gpirq_unit #(.NPINS(NP)) u_gpirq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    function automatic logic [NP-1:0] exp_raw(input logic [NP-1:0] pins);
        return (m_lvl & ~(pins ^ m_pol)) | (~m_lvl & m_latch);
    endfunction

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive at falling edge, update model at rising edge
    task automatic tick(input logic [NP-1:0] pins, input logic wr,
                        input logic [11:0] addr, input logic [NP-1:0] data);
        logic [NP-1:0] rise, fall, hit, clr;
        @(negedge clk);
        pin_in = pins; bus_sel = wr; bus_wr = wr; bus_addr = addr; bus_wdata = data;
        @(posedge clk);
        rise = pins & ~m_prev;
        fall = ~pins & m_prev;
        hit  = ~m_lvl & ((m_dual & (rise | fall)) | (~m_dual & m_pol & rise) | (~m_dual & ~m_pol & fall));
        clr  = (wr && addr == A_CLR) ? data : '0;
        m_irq   = |(exp_raw(pins) & m_en);
        m_latch = ((m_latch & ~clr) | hit) & ~m_lvl;
        m_prev  = pins;
        if (wr) begin
            case (addr)
                A_KIND: m_lvl  = data;
                A_DUAL: m_dual = data;
                A_POL:  m_pol  = data;
                A_EN:   m_en   = data;
                default: ;
            endcase
        end
        #0.5;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] addr, input logic [NP-1:0] exp, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
        #0.4;
        check(tag, bus_rdata, exp);
        bus_sel = 1'b0;
        #0.1;
    endtask

    task automatic check_all(input string tag);
        rd(A_RAW, exp_raw(pin_in), {tag, " raw"});
        rd(A_MSK, exp_raw(pin_in) & m_en, "R9 masked");
        check("R10 irq_out", {{(NP-1){1'b0}}, irq_out}, {{(NP-1){1'b0}}, m_irq});
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #0.5;

        // R1 reset state
        rd(A_KIND, '0, "R1 kind"); rd(A_DUAL, '0, "R1 dual");
        rd(A_POL, '0, "R1 pol");   rd(A_EN, '0, "R1 enable");
        rd(A_RAW, '0, "R1 raw");   rd(A_MSK, '0, "R1 masked");
        check("R1 irq_out", {{(NP-1){1'b0}}, irq_out}, '0);

        // R2 readback
        tick('0, 1, A_KIND, 8'hA5); tick('0, 1, A_DUAL, 8'h3C);
        tick('0, 1, A_POL, 8'h96);  tick('0, 1, A_EN, 8'hF0);
        rd(A_KIND, 8'hA5, "R2 kind"); rd(A_DUAL, 8'h3C, "R2 dual");
        rd(A_POL, 8'h96, "R2 pol");   rd(A_EN, 8'hF0, "R2 enable");
        check_all("R8 level after config");

        // R11 status offsets are read-only, clear/unmapped read zero
        tick('0, 1, A_RAW, 8'hFF); tick('0, 1, A_MSK, 8'hFF);
        check_all("R11 write to status");
        rd(A_CLR, '0, "R11 clear offset read");
        rd(12'h400, '0, "R11 unmapped low");
        rd(12'h420, '0, "R11 unmapped high");
        tick('0, 1, A_KIND, '0); tick('0, 1, A_DUAL, '0);
        tick('0, 1, A_POL, 8'h01); tick('0, 1, A_EN, 8'h01);
        tick('0, 1, A_CLR, 8'hFF);

        // R3 and R6: rising edge latches, sticky, write-0 no effect, write-1 clears
        tick(8'h01, 0, '0, '0); check_all("R3 rising edge");
        tick(8'h00, 0, '0, '0); check_all("R6 stays after fall");
        rd(A_RAW, 8'h01, "R6 sticky bit0");
        tick(8'h00, 1, A_CLR, 8'h00); rd(A_RAW, 8'h01, "R6 write zero keeps");
        tick(8'h00, 1, A_CLR, 8'h01); rd(A_RAW, 8'h00, "R6 write one clears");
        check_all("R6 after clear");

        // R7: edge and clear in the same cycle
        tick(8'h01, 1, A_CLR, 8'h01); rd(A_RAW, 8'h01, "R7 edge beats clear");
        check_all("R7 model");

        // R8 clear has no effect on level pin; R12 no stale latch
        tick(8'h00, 1, A_KIND, 8'h01);
        rd(A_RAW, 8'h00, "R12 level low with pol high");
        tick(8'h01, 0, '0, '0); rd(A_RAW, 8'h01, "R8 level live high");
        tick(8'h01, 1, A_CLR, 8'h01); rd(A_RAW, 8'h01, "R8 clear ignored on level");
        tick(8'h00, 0, '0, '0); rd(A_RAW, 8'h00, "R8 level drops");
        tick(8'h00, 1, A_KIND, 8'h00); rd(A_RAW, 8'h00, "R12 no stale latch");

        // sweep: every pin through every trigger setting, neighbours mixed
        for (int i = 0; i < NP; i++) begin
            for (int m = 0; m < 5; m++) begin
                logic [NP-1:0] k, d, p, e, pat;
                string tag;
                k = '0; d = '0; p = '0;
                for (int q = 0; q < NP; q++) begin
                    int md;
                    md = (m + q) % 5;
                    k[q] = (md >= 3);
                    d[q] = (md == 2);
                    p[q] = (md == 0) || (md == 3);
                end
                e   = (m % 2 == 1) ? 8'hFF : (8'h01 << i);
                pat = 8'hC3 ^ (8'h01 << i);
                case (m)
                    0: tag = "R3 rise sweep";
                    1: tag = "R4 fall sweep";
                    2: tag = "R5 dual sweep";
                    3: tag = "R8 level-high sweep";
                    default: tag = "R8 level-low sweep";
                endcase
                tick(pin_in, 1, A_KIND, k); tick(pin_in, 1, A_DUAL, d);
                tick(pin_in, 1, A_POL, p);  tick(pin_in, 1, A_EN, e);
                tick(pin_in, 1, A_CLR, 8'hFF); check_all(tag);
                tick('0, 0, '0, '0);          check_all(tag);
                tick(pat, 0, '0, '0);         check_all(tag);
                tick(pat, 0, '0, '0);         check_all(tag);
                tick(pat, 1, A_CLR, 8'h0F);   check_all(tag);
                tick(~pat, 1, A_CLR, 8'hFF);  check_all(tag);
                tick(~pat, 0, '0, '0);        check_all(tag);
                tick('0, 1, A_CLR, 8'hF0);    check_all(tag);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule